// File: doc/BRIEF.md
# Playback Format Decoder with Byte-Count Interrupt

This block sits beside a playback DMA channel. It decodes a single format byte into three things: a sample-rate selection, a mono or stereo flag, and a sample encoding. It checks that this combination is legal. It also counts the bytes the DMA moves. Once that count reaches a programmed sample count, scaled to bytes, the block raises a playback interrupt.

Software writes the format byte and pulses `fmt_load`. A legal byte replaces the held decode. An illegal byte raises `fmt_err`, keeps the previous decode and withdraws the DMA request. While interrupt counting is enabled, each `xfer_stb` pulse stands for one byte consumed. The byte threshold is `base_count` shifted left by an amount that depends on the sample width and the channel count. On reaching the threshold the interrupt flag is set and the count starts again from zero. The flag stays set until `irq_clr` is pulsed.

Top module: `pbk_fmt_irq`

## Requirements
- R1: After reset the block reports the following state: rate code 0 with the rate marked valid, mono, encoding 0, no format error, interrupt flag low and byte count zero.
- R2: On a `fmt_load` cycle:
  - Bits 3:0 of the byte become `rate_idx`. Bit 0 picks the crystal and bits 3:1 the rate within it.
  - `rate_valid` is cleared only for the two unused codes 4'h8 and 4'hA, which have bit 0 clear and bits 3:1 equal to 4 or 5. An unused code also sets `fmt_err`.
- R3: On a valid load, format bit 4 sets `stereo` (1 = two channels) and clears it for mono.
- R4: The encoding is format bits 7:5 ANDed with 3'b111 when `ext_mode` is high and with 3'b011 when it is low. Legal codes are: 0 unsigned 8-bit, 1 mu-law, 2 signed 16-bit little-endian, 3 A-law, 6 signed 16-bit big-endian.
- R5: An encoding of 4, 5 or 7, or an unused rate, sets `fmt_err`. In that case `rate_idx`, `stereo` and `enc` keep their previous values. A later legal load clears `fmt_err`.
- R6: `dma_req_en` is high exactly when `play_en` is high and `fmt_err` is low.
- R7: The byte threshold is `base_count` shifted left by a shift amount:
  - Encodings 0, 1 and 3: the shift is 1 for stereo and 0 for mono.
  - Encodings 2 and 6: the shift is 2 for stereo and 1 for mono.
- R8: Counting is enabled when `irq_en` is high. Each enabled `xfer_stb` adds one byte. The strobe that brings the count to or past the threshold does three things: it sets `irq_flag` at that clock edge, it returns the count to zero, and it does not add a byte.
- R9: `irq_clr` clears `irq_flag`. If the threshold is reached in the same cycle, setting wins.
- R10: A low-to-high change of `play_en` clears the byte count. Strobes are ignored while `irq_en` is low, and the count is held.
- R11: A zero threshold disables counting, and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_byte | input | 8 | Format byte |
| fmt_load | input | 1 | Apply `fmt_byte` this cycle |
| ext_mode | input | 1 | Extended mode: widens the encoding field to 3 bits |
| play_en | input | 1 | Playback enable |
| irq_en | input | 1 | Enable byte counting and interrupt |
| base_count | input | CNT_W | Programmed sample count |
| xfer_stb | input | 1 | One byte consumed by DMA |
| irq_clr | input | 1 | Clear interrupt flag |
| rate_idx | output | 4 | Crystal select and rate index |
| rate_valid | output | 1 | Last loaded rate code was usable |
| stereo | output | 1 | Two channels |
| enc | output | 3 | Decoded encoding code |
| fmt_err | output | 1 | Last load was rejected |
| dma_req_en | output | 1 | DMA request enable |
| irq_flag | output | 1 | Playback interrupt pending |

## Verification
The bench builds the block with `CNT_W` = 4. With that width the largest threshold is 60 bytes. Every shift amount, the threshold wrap and the zero threshold can therefore each be reached in a few dozen strobes. The count width still keeps its two guard bits above the base count, so the stereo 16-bit case exercises the full shifted width.

// File: rtl/pfi_pkg.sv
package pfi_pkg;
  typedef enum logic [2:0] {
    ENC_U8    = 3'd0,
    ENC_ULAW  = 3'd1,
    ENC_S16LE = 3'd2,
    ENC_ALAW  = 3'd3,
    ENC_RSV4  = 3'd4,
    ENC_ADPCM = 3'd5,
    ENC_S16BE = 3'd6,
    ENC_RSV7  = 3'd7
  } pfi_enc_e;

  localparam int unsigned SHIFT_W = 2;

  function automatic logic enc_legal(input logic [2:0] code);
    return (code == ENC_U8) || (code == ENC_ULAW) || (code == ENC_S16LE) ||
           (code == ENC_ALAW) || (code == ENC_S16BE);
  endfunction
endpackage

// File: rtl/pfi_fmt_decode.sv
module pfi_fmt_decode
  import pfi_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] fmt_byte,
  input  logic       fmt_load,
  input  logic       ext_mode,
  output logic [3:0] rate_idx,
  output logic       rate_valid,
  output logic       stereo,
  output logic [2:0] enc,
  output logic       fmt_err,
  output logic [SHIFT_W-1:0] shamt
);
  logic [3:0] rate_q, rate_d;
  logic       rv_q, rv_d, st_q, st_d, err_q, err_d;
  logic [2:0] enc_q, enc_d;
  logic [2:0] code_w;
  logic       rate_ok, ok_w, wide_w;

  always_comb begin
    code_w  = fmt_byte[7:5] & (ext_mode ? 3'b111 : 3'b011);
    rate_ok = fmt_byte[0] | (fmt_byte[3:2] != 2'b10);
    ok_w    = rate_ok & enc_legal(code_w);
    rate_d  = rate_q;
    rv_d    = rv_q;
    st_d    = st_q;
    enc_d   = enc_q;
    err_d   = err_q;
    if (fmt_load) begin
      rv_d  = rate_ok;
      err_d = ~ok_w;
      if (ok_w) begin
        rate_d = fmt_byte[3:0];
        st_d   = fmt_byte[4];
        enc_d  = code_w;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      rv_q   <= 1'b1;
      st_q   <= 1'b0;
      enc_q  <= ENC_U8;
      err_q  <= 1'b0;
    end else if (fmt_load) begin
      rate_q <= rate_d;
      rv_q   <= rv_d;
      st_q   <= st_d;
      enc_q  <= enc_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    wide_w = (enc_q == ENC_S16LE) || (enc_q == ENC_S16BE);
    if (wide_w) shamt = st_q ? SHIFT_W'(2) : SHIFT_W'(1);
    else        shamt = st_q ? SHIFT_W'(1) : SHIFT_W'(0);
  end

  assign rate_idx   = rate_q;
  assign rate_valid = rv_q;
  assign stereo     = st_q;
  assign enc        = enc_q;
  assign fmt_err    = err_q;

  // R5: a rejected load leaves the held decode untouched
  a_r5_keep_decode: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_load && !ok_w) |=> ($stable(rate_q) && $stable(enc_q) && $stable(st_q) && err_q));
  // R5: a legal load clears the error
  a_r5_err_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_load && ok_w) |=> !err_q);
  // R2: the two unused rate codes are flagged
  a_r2_bad_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_load && !fmt_byte[0] && (fmt_byte[3:1] == 3'd4 || fmt_byte[3:1] == 3'd5)) |=> (!rv_q && err_q));
endmodule

// File: rtl/pfi_byte_counter.sv
module pfi_byte_counter
  import pfi_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   base_count,
  input  logic [SHIFT_W-1:0] shamt,
  input  logic               play_en,
  input  logic               irq_en,
  input  logic               xfer_stb,
  input  logic               irq_clr,
  output logic               irq_flag
);
  localparam int unsigned THR_W = CNT_W + 2;

  logic [THR_W-1:0] cnt_q, cnt_d, thr_w;
  logic [THR_W:0]   cnt_inc;
  logic             irq_q, irq_d, play_q, rise_w, adv_w, hit_w;

  always_comb begin
    thr_w   = THR_W'(base_count) << shamt;
    rise_w  = play_en & ~play_q;
    adv_w   = xfer_stb & irq_en & (thr_w != '0);
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    hit_w   = 1'b0;
    cnt_d   = cnt_q;
    if (rise_w) begin
      cnt_d = '0;
    end else if (adv_w) begin
      if (cnt_inc >= {1'b0, thr_w}) begin
        cnt_d = '0;
        hit_w = 1'b1;
      end else begin
        cnt_d = cnt_inc[THR_W-1:0];
      end
    end
    irq_d = hit_w ? 1'b1 : (irq_clr ? 1'b0 : irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      irq_q  <= 1'b0;
      play_q <= 1'b0;
    end else begin
      if (rise_w || adv_w) cnt_q <= cnt_d;
      if (hit_w || irq_clr) irq_q <= irq_d;
      play_q <= play_en;
    end
  end

  assign irq_flag = irq_q;

  // R10: enabling playback restarts the count
  a_r10_clear_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (play_en && !play_q) |=> (cnt_q == '0));
  // R10, R11: no advance without irq_en or with a zero threshold
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ((!irq_en || base_count == '0) && !(play_en && !play_q)) |=> $stable(cnt_q));
  // R8: reaching the threshold restarts the count and raises the flag
  a_r8_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_w && play_q) |=> (cnt_q == '0 && irq_q));
  // R9: a clear without a coincident hit drops the flag
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !hit_w) |=> !irq_q);
endmodule

// File: rtl/pbk_fmt_irq.sv
module pbk_fmt_irq
  import pfi_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       fmt_byte,
  input  logic             fmt_load,
  input  logic             ext_mode,
  input  logic             play_en,
  input  logic             irq_en,
  input  logic [CNT_W-1:0] base_count,
  input  logic             xfer_stb,
  input  logic             irq_clr,
  output logic [3:0]       rate_idx,
  output logic             rate_valid,
  output logic             stereo,
  output logic [2:0]       enc,
  output logic             fmt_err,
  output logic             dma_req_en,
  output logic             irq_flag
);
  logic [SHIFT_W-1:0] shamt;

  pfi_fmt_decode u_dec (
    .clk(clk), .rst_n(rst_n), .fmt_byte(fmt_byte), .fmt_load(fmt_load),
    .ext_mode(ext_mode), .rate_idx(rate_idx), .rate_valid(rate_valid),
    .stereo(stereo), .enc(enc), .fmt_err(fmt_err), .shamt(shamt)
  );

  pfi_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .base_count(base_count), .shamt(shamt),
    .play_en(play_en), .irq_en(irq_en), .xfer_stb(xfer_stb),
    .irq_clr(irq_clr), .irq_flag(irq_flag)
  );

  assign dma_req_en = play_en & ~fmt_err;

  // R6: request only while enabled with an accepted format
  a_r6_dreq: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_en |-> (play_en && !fmt_err));
  // R4: the held encoding is always a legal code
  a_r4_legal_enc: assert property (@(posedge clk) disable iff (!rst_n)
    (enc != 3'd4 && enc != 3'd5 && enc != 3'd7));
endmodule

// File: tb/sim_pbk_fmt_irq.sv
module sim_pbk_fmt_irq;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] fmt_byte = '0;
  logic fmt_load = 0, ext_mode = 0, play_en = 0, irq_en = 0, xfer_stb = 0, irq_clr = 0;
  logic [CW-1:0] base_count = '0;
  logic [3:0] rate_idx;
  logic rate_valid, stereo, fmt_err, dma_req_en, irq_flag;
  logic [2:0] enc;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pbk_fmt_irq #(.CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .fmt_byte(fmt_byte), .fmt_load(fmt_load),
    .ext_mode(ext_mode), .play_en(play_en), .irq_en(irq_en),
    .base_count(base_count), .xfer_stb(xfer_stb), .irq_clr(irq_clr),
    .rate_idx(rate_idx), .rate_valid(rate_valid), .stereo(stereo), .enc(enc),
    .fmt_err(fmt_err), .dma_req_en(dma_req_en), .irq_flag(irq_flag)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // behavioural reference
  int m_rate, m_rv, m_st, m_enc, m_err, m_cnt, m_irq, m_prev;

  function automatic int shift_of(input int e, input int s);
    if (e == 2 || e == 6) return s ? 2 : 1;
    return s ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rate = 0; m_rv = 1; m_st = 0; m_enc = 0; m_err = 0;
      m_cnt = 0; m_irq = 0; m_prev = 0;
    end else begin
      int thr, code, rsel;
      bit hit, rok, eok;
      thr = int'(base_count) * (1 << shift_of(m_enc, m_st));
      hit = 0;
      if (play_en && !m_prev) m_cnt = 0;
      else if (xfer_stb && irq_en && thr != 0) begin
        if (m_cnt + 1 >= thr) begin m_cnt = 0; hit = 1; end
        else m_cnt = m_cnt + 1;
      end
      if (hit) m_irq = 1; else if (irq_clr) m_irq = 0;
      m_prev = play_en;
      if (fmt_load) begin
        rsel = (fmt_byte >> 1) & 7;
        rok  = !((fmt_byte & 1) == 0 && (rsel == 4 || rsel == 5));
        code = (fmt_byte >> 5) & (ext_mode ? 7 : 3);
        eok  = !(code == 4 || code == 5 || code == 7);
        m_rv = rok;
        m_err = !(rok && eok);
        if (!m_err) begin m_rate = fmt_byte & 15; m_st = (fmt_byte >> 4) & 1; m_enc = code; end
      end
    end
  end

  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R2", "rate_idx", rate_idx, m_rate);
      chk("R2", "rate_valid", rate_valid, m_rv);
      chk("R3", "stereo", stereo, m_st);
      chk("R4", "enc", enc, m_enc);
      chk("R5", "fmt_err", fmt_err, m_err);
      chk("R6", "dma_req_en", dma_req_en, play_en && !m_err);
      chk("R8", "irq_flag", irq_flag, m_irq);
    end
  end

  task automatic load(input logic [7:0] b, input logic m2);
    fmt_byte = b; ext_mode = m2; fmt_load = 1;
    @(negedge clk); fmt_load = 0;
    @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin xfer_stb = 1; @(negedge clk); end
    xfer_stb = 0;
  endtask

  task automatic clear_irq();
    irq_clr = 1; @(negedge clk); irq_clr = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1", "reset rate", rate_idx, 0);
    chk("R1", "reset rate_valid", rate_valid, 1);
    chk("R1", "reset stereo", stereo, 0);
    chk("R1", "reset enc", enc, 0);
    chk("R1", "reset err", fmt_err, 0);
    chk("R1", "reset irq", irq_flag, 0);

    // R2: rates
    load(8'h07, 0); chk("R2", "rate 7", rate_idx, 7);
    load(8'h08, 0); chk("R2", "unused rate valid", rate_valid, 0);
    chk("R2", "unused rate kept", rate_idx, 7);
    load(8'h0B, 0); chk("R2", "rate B", rate_idx, 11); chk("R2", "rate B valid", rate_valid, 1);
    load(8'h0A, 0); chk("R5", "unused rate A err", fmt_err, 1);
    // R3, R4
    load(8'h13, 0); chk("R3", "stereo", stereo, 1);
    load(8'hC0, 0); chk("R4", "masked to 2", enc, 2); chk("R3", "mono", stereo, 0);
    load(8'hC0, 1); chk("R4", "big-endian 6", enc, 6);
    load(8'h60, 1); chk("R4", "a-law", enc, 3);
    // R5 rejects
    load(8'h80, 1); chk("R5", "code 4 err", fmt_err, 1); chk("R5", "code 4 kept", enc, 3);
    load(8'hB1, 1); chk("R5", "code 5 err", fmt_err, 1); chk("R5", "code 5 kept", stereo, 0);
    load(8'hE0, 1); chk("R5", "code 7 err", fmt_err, 1);
    play_en = 1; @(negedge clk);
    chk("R6", "dreq off on err", dma_req_en, 0);
    load(8'hE0, 0); chk("R5", "code 3 via mask", fmt_err, 0); chk("R6", "dreq on", dma_req_en, 1);

    // R8 mono 8-bit, base 3 -> 3 bytes
    play_en = 0; @(negedge clk);
    load(8'h00, 0); base_count = 3; irq_en = 1; play_en = 1; @(negedge clk);
    pulses(2); chk("R8", "before threshold", irq_flag, 0);
    pulses(1); chk("R8", "at threshold", irq_flag, 1);
    clear_irq(); chk("R9", "cleared", irq_flag, 0);
    pulses(2); chk("R8", "count restarted", irq_flag, 0);
    pulses(1); chk("R8", "second wrap", irq_flag, 1);
    clear_irq();

    // R7 stereo 16-bit: 3 << 2 = 12
    load(8'h50, 0);
    pulses(11); chk("R7", "stereo16 at 11", irq_flag, 0);
    pulses(1);  chk("R7", "stereo16 at 12", irq_flag, 1);
    clear_irq();
    load(8'h10, 0); // stereo u8: 6
    pulses(5); chk("R7", "stereo8 at 5", irq_flag, 0);
    pulses(1); chk("R7", "stereo8 at 6", irq_flag, 1);
    clear_irq();
    load(8'hC0, 1); // mono BE: 6
    pulses(5); chk("R7", "mono16 at 5", irq_flag, 0);
    pulses(1); chk("R7", "mono16 at 6", irq_flag, 1);
    clear_irq();
    base_count = 15; load(8'h50, 0); // 60
    pulses(59); chk("R7", "max at 59", irq_flag, 0);
    pulses(1);  chk("R7", "max at 60", irq_flag, 1);
    clear_irq();

    // R9 set wins over clear
    load(8'h00, 0); base_count = 2;
    pulses(1);
    xfer_stb = 1; irq_clr = 1; @(negedge clk); xfer_stb = 0; irq_clr = 0;
    chk("R9", "set wins", irq_flag, 1);
    clear_irq();

    // R10 enable edge clears count
    base_count = 3; pulses(2);
    play_en = 0; @(negedge clk); play_en = 1; @(negedge clk);
    pulses(2); chk("R10", "restart after enable", irq_flag, 0);
    pulses(1); chk("R10", "third after enable", irq_flag, 1);
    clear_irq();
    // R10 hold while irq_en low
    pulses(1); irq_en = 0; pulses(5); chk("R10", "ignored while disabled", irq_flag, 0);
    irq_en = 1; pulses(1); chk("R10", "held count 2", irq_flag, 0);
    pulses(1); chk("R10", "held count 3", irq_flag, 1);
    clear_irq();
    // R11 zero threshold
    base_count = 0; pulses(40); chk("R11", "zero base no irq", irq_flag, 0);

    // mixed patterns against the model
    for (int k = 0; k < 400; k++) begin
      fmt_byte = 8'($urandom); ext_mode = 1'($urandom);
      fmt_load = ($urandom % 16) == 0;
      play_en = ($urandom % 32) != 0;
      irq_en = ($urandom % 8) != 0;
      base_count = CW'($urandom);
      xfer_stb = 1'($urandom);
      irq_clr = ($urandom % 6) == 0;
      @(negedge clk);
    end
    fmt_load = 0; xfer_stb = 0; irq_clr = 0;
    @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule